// File: doc/BRIEF.md
# Strip Hit Trigger Primitive Selector

This block produces trigger primitives from the binary hit pattern of a strip readout chip. On every clock it takes the comparator hit vector and reduces it to a short list of candidates that suggest a high-transverse-momentum track. No correlation logic outside the chip is involved.

In cluster mode, the block looks for runs of adjacent hit strips on a single sensor. A narrow run points to a stiff track, so only runs no wider than a programmable maximum are kept. For each run that passes, the block reports the index of the first strip and the run width.

In stacked mode, the inputs hold two sensor layers bonded to interleaved channels. The block reports every upper-layer position that has a lower-layer hit within a programmable number of positions on either side.

Results are registered. They appear one clock after the hits are sampled, as up to four slots ordered by address, plus a flag that marks a truncated list.

Top module: `strip_trig_prim`

## Requirements
- R1: While `rst_n` is low, `res_valid_o` and `overflow_o` are 0, and all address and width slots are 0.
- R2: The results for the hits, mode and settings presented before a rising clock edge appear on the outputs after that edge and stay until the next edge.
- R3: In cluster mode, a cluster is a maximal run of set bits in `hits_i`. Its address is the lowest bit index in the run and its width is the number of bits in the run.
- R4: In cluster mode, a cluster is reported only when its width is at most `max_width_i`. With `max_width_i` = 0 no cluster is reported, and runs of 8 or more bits are never reported.
- R5: In stacked mode, bit 2q of `hits_i` is lower-layer position q and bit 2p+1 is upper-layer position p (positions 0..63). An upper hit at p is reported with address p and width 0 when there is a lower hit at some q with |p-q| <= `window_i`.
- R6: `window_i` takes values from 0 to 3. A lower hit exactly `window_i` positions away qualifies; one that is `window_i`+1 positions away does not.
- R7: Qualified results fill slots from slot 0 in ascending address order, and the valid bits form a contiguous run starting at slot 0. Slot k uses `res_addr_o[7k+6:7k]`, `res_width_o[3k+2:3k]` and `res_valid_o[k]`. Slots that are not valid read 0.
- R8: When more than 4 results qualify, `overflow_o` is 1 and the 4 lowest addresses are reported. When 4 or fewer qualify, `overflow_o` is 0.
- R9: `mode_i` = 0 selects cluster mode and `mode_i` = 1 selects stacked mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = cluster mode, 1 = stacked mode |
| max_width_i | input | 3 | Largest cluster width that passes |
| window_i | input | 2 | Coincidence half-window in positions |
| hits_i | input | 128 | Binary comparator hits |
| res_valid_o | output | 4 | Slot valid bits |
| res_addr_o | output | 28 | Four 7-bit result addresses |
| res_width_o | output | 12 | Four 3-bit cluster widths |
| overflow_o | output | 1 | More than four results qualified |

## Verification
Single hits at both ends of the vector check address encoding at the boundaries. Runs of width 7, 8 and a spread of widths from 1 to 6 pin down the exact cut of the width filter, including the setting that passes nothing. In stacked mode, lower hits placed exactly at and one beyond the window separate an inclusive comparison from an exclusive one, and lone upper or lone lower hits confirm that both layers are required. Five versus four qualifying results bracket the overflow threshold. The same vector fed in both modes checks the mode decode, and long runs of sparse random vectors in random modes check ordering and slot packing against a queue-based model.

// File: rtl/strip_trig_prim.sv
module strip_trig_prim #(
  parameter int NCH  = 128,
  parameter int NOUT = 4,
  parameter int WW   = 3,
  parameter int WINW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic [WW-1:0]        max_width_i,
  input  logic [WINW-1:0]      window_i,
  input  logic [NCH-1:0]       hits_i,
  output logic [NOUT-1:0]      res_valid_o,
  output logic [NOUT*AW-1:0]   res_addr_o,
  output logic [NOUT*WW-1:0]   res_width_o,
  output logic                 overflow_o
);
  localparam int AW     = $clog2(NCH);
  localparam int SW     = $clog2(NOUT);
  localparam int NPOS   = NCH / 2;
  localparam int MAXRUN = (1 << WW) - 1;
  localparam int MAXWIN = (1 << WINW) - 1;
  localparam int LXW    = NPOS + 2 * MAXWIN;

  logic [NCH+MAXRUN:0] hits_ext;
  logic [NCH-1:0]      run_first;
  logic [NCH-1:0]      clu_cand, stk_cand, cand;
  logic [WW-1:0]       clu_len [NCH];
  logic [LXW-1:0]      lower_ext;
  logic [NPOS-1:0]     upper;

  assign hits_ext  = {{(MAXRUN+1){1'b0}}, hits_i};
  assign run_first = hits_i & ~{hits_i[NCH-2:0], 1'b0};

  assign lower_ext[MAXWIN-1:0]       = '0;
  assign lower_ext[LXW-1:NPOS+MAXWIN] = '0;
  for (genvar q = 0; q < NPOS; q++) begin : g_layers
    assign lower_ext[q+MAXWIN] = hits_i[2*q];
    assign upper[q]            = hits_i[2*q+1];
  end

  int   run_len;
  logic alive;
  always_comb begin
    clu_cand = '0;
    run_len  = 0;
    alive    = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      run_len = 0;
      alive   = 1'b1;
      for (int k = 0; k <= MAXRUN; k++) begin
        if (alive && hits_ext[i+k]) run_len++;
        else alive = 1'b0;
      end
      clu_len[i]  = WW'(run_len);
      clu_cand[i] = run_first[i] && (run_len <= int'(max_width_i));
    end
  end

  logic near;
  always_comb begin
    stk_cand = '0;
    near     = 1'b0;
    for (int p = 0; p < NPOS; p++) begin
      near = 1'b0;
      for (int d = -MAXWIN; d <= MAXWIN; d++) begin
        if (((d < 0) ? -d : d) <= int'(window_i)) near = near | lower_ext[p+d+MAXWIN];
      end
      stk_cand[p] = upper[p] & near;
    end
  end

  assign cand = mode_i ? stk_cand : clu_cand;

  logic [NOUT-1:0]    nxt_valid;
  logic [NOUT*AW-1:0] nxt_addr;
  logic [NOUT*WW-1:0] nxt_width;
  logic               nxt_ovf;
  int                 found;
  always_comb begin
    nxt_valid = '0;
    nxt_addr  = '0;
    nxt_width = '0;
    found     = 0;
    for (int i = 0; i < NCH; i++) begin
      if (cand[i]) begin
        if (found < NOUT) begin
          nxt_valid[found[SW-1:0]]  = 1'b1;
          nxt_addr[found*AW +: AW]  = AW'(i);
          nxt_width[found*WW +: WW] = mode_i ? '0 : clu_len[i];
        end
        found++;
      end
    end
    nxt_ovf = (found > NOUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= '0;
      res_addr_o  <= '0;
      res_width_o <= '0;
      overflow_o  <= 1'b0;
    end else begin
      res_valid_o <= nxt_valid;
      res_addr_o  <= nxt_addr;
      res_width_o <= nxt_width;
      overflow_o  <= nxt_ovf;
    end
  end
endmodule

module strip_trig_chk #(
  parameter int NCH  = 128,
  parameter int NOUT = 4,
  parameter int WW   = 3,
  parameter int AW   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_i,
  input logic [WW-1:0]      max_width_i,
  input logic [NOUT-1:0]    res_valid_o,
  input logic [NOUT*AW-1:0] res_addr_o,
  input logic [NOUT*WW-1:0] res_width_o,
  input logic               overflow_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (res_valid_o == '0 && !overflow_o));

  p_packed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_valid_o + 1'b1) & res_valid_o) == '0);

  p_full_on_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (&res_valid_o));

  for (genvar k = 0; k < NOUT; k++) begin : g_slot
    p_width_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o[k] && !$past(mode_i)) |->
        (res_width_o[k*WW +: WW] != '0 && res_width_o[k*WW +: WW] <= $past(max_width_i)));
    p_stack_format_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o[k] && $past(mode_i)) |->
        (res_width_o[k*WW +: WW] == '0 && int'(res_addr_o[k*AW +: AW]) < NCH/2));
    if (k < NOUT-1) begin : g_ord
      p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o[k+1] |-> (res_addr_o[(k+1)*AW +: AW] > res_addr_o[k*AW +: AW]));
    end
  end
endmodule

bind strip_trig_prim strip_trig_chk #(.NCH(NCH), .NOUT(NOUT), .WW(WW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .max_width_i(max_width_i),
  .res_valid_o(res_valid_o), .res_addr_o(res_addr_o),
  .res_width_o(res_width_o), .overflow_o(overflow_o)
);

// File: tb/tb_strip_trig_prim.sv
module tb_strip_trig_prim;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode;
  logic [2:0]   mw;
  logic [1:0]   win;
  logic [127:0] hits;
  logic [3:0]   valid;
  logic [27:0]  addr;
  logic [11:0]  width;
  logic         ovf;

  always #4 clk = ~clk;

  strip_trig_prim dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .max_width_i(mw), .window_i(win),
    .hits_i(hits), .res_valid_o(valid), .res_addr_o(addr), .res_width_o(width),
    .overflow_o(ovf)
  );

  int checks = 0;
  int fails  = 0;
  logic        pend = 1'b0;
  string       pend_tag;
  logic [3:0]  ev;
  logic [27:0] ea;
  logic [11:0] ew;
  logic        eo;

  function automatic logic [127:0] run(int s, int len);
    logic [127:0] r = '0;
    for (int i = 0; i < len; i++) if (s + i < 128) r[s+i] = 1'b1;
    return r;
  endfunction

  task automatic model(input logic [127:0] h, input logic m, input logic [2:0] w_max,
                       input logic [1:0] w_win);
    int qa[$];
    int qw[$];
    if (!m) begin
      int i = 0;
      while (i < 128) begin
        if (h[i]) begin
          int j = i;
          while (j < 128 && h[j]) j++;
          if (j - i <= int'(w_max)) begin qa.push_back(i); qw.push_back(j - i); end
          i = j;
        end else i++;
      end
    end else begin
      for (int p = 0; p < 64; p++) begin
        if (h[2*p+1]) begin
          bit ok = 0;
          for (int q = p - int'(w_win); q <= p + int'(w_win); q++)
            if (q >= 0 && q < 64 && h[2*q]) ok = 1;
          if (ok) begin qa.push_back(p); qw.push_back(0); end
        end
      end
    end
    ev = '0; ea = '0; ew = '0;
    eo = (qa.size() > 4);
    for (int k = 0; k < 4 && k < qa.size(); k++) begin
      ev[k] = 1'b1;
      ea[k*7 +: 7] = 7'(qa[k]);
      ew[k*3 +: 3] = 3'(qw[k]);
    end
  endtask

  task automatic compare(input string tag, input logic [3:0] xv, input logic [27:0] xa,
                         input logic [11:0] xw, input logic xo);
    checks++;
    if (valid !== xv || addr !== xa || width !== xw || ovf !== xo) begin
      fails++;
      $display("FAIL %s: valid=%b addr=%h width=%h ovf=%b expected valid=%b addr=%h width=%h ovf=%b",
               tag, valid, addr, width, ovf, xv, xa, xw, xo);
    end
  endtask

  task automatic step(input logic [127:0] h, input logic m, input logic [2:0] w_max,
                      input logic [1:0] w_win, input string tag);
    @(negedge clk);
    if (pend) compare(pend_tag, ev, ea, ew, eo);
    hits = h; mode = m; mw = w_max; win = w_win;
    model(h, m, w_max, w_win);
    pend_tag = tag;
    pend = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0; mw = 3'd7; win = 2'd0;
    hits = run(3, 2) | run(60, 1);
    repeat (3) @(negedge clk);
    compare("R1 reset state", 4'b0, 28'h0, 12'h0, 1'b0);
    rst_n = 1'b1;

    step('0, 0, 7, 0, "R3 empty vector");
    step(run(0, 1), 0, 7, 0, "R3 single hit at strip 0");
    step(run(127, 1), 0, 7, 0, "R3 single hit at strip 127");
    step(run(5, 3) | run(20, 2), 0, 7, 0, "R3 two clusters");
    step(run(40, 7), 0, 7, 0, "R4 width 7 passes at max 7");
    step(run(40, 7), 0, 6, 0, "R4 width 7 dropped at max 6");
    step(run(40, 8), 0, 7, 0, "R4 run of 8 dropped");
    step(run(1, 1), 0, 0, 0, "R4 max width 0 passes none");
    step(run(2,1)|run(10,2)|run(20,3)|run(30,4)|run(45,5)|run(60,6), 0, 3, 0, "R4 widths 1..6 at max 3");
    step(run(10,1)|run(20,1)|run(30,1)|run(40,1)|run(50,1), 0, 7, 0, "R8 five clusters overflow");
    step(run(10,1)|run(20,1)|run(30,1)|run(40,1), 0, 7, 0, "R8 exactly four no overflow");
    step(run(21,1)|run(26,1), 1, 3, 3, "R6 lower at distance 3 window 3");
    step(run(21,1)|run(26,1), 1, 3, 2, "R6 lower at distance 3 window 2");
    step(run(20,2), 1, 3, 0, "R5 window 0 same position");
    step(run(0,2), 1, 3, 0, "R5 position 0");
    step(run(126,2) | run(124,1), 1, 3, 1, "R5 position 63");
    step(run(126,2), 1, 3, 0, "R5 position 63 window 0");
    step(run(40,1), 1, 3, 3, "R5 lower only");
    step(run(41,1), 1, 3, 3, "R5 upper only");
    step(run(0,12), 1, 3, 0, "R8 stacked six coincidences");
    step(run(20,2), 0, 7, 0, "R9 mode 0 on pair");
    step(run(20,2), 1, 7, 0, "R9 mode 1 on pair");
    step(run(70,2), 0, 7, 0, "R2 pattern");
    step('0, 0, 7, 0, "R2 clears after one clock");
    for (int n = 0; n < 500; n++) begin
      logic [127:0] r;
      r = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      if (n % 2 == 0) r = r & {$urandom, $urandom, $urandom, $urandom};
      step(r, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
           "R7 random ordering and packing");
    end
    step('0, 0, 7, 0, "R2 flush");
    @(negedge clk);
    compare(pend_tag, ev, ea, ew, eo);
    pend = 1'b0;
    hits = run(10,1) | run(20,1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    compare("R1 reset during run", 4'b0, 28'h0, 12'h0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule